// File: doc/BRIEF.md
# Single-Cycle MIPS-Subset Processor Core

This block is a processor core that completes one instruction in every clock cycle. It executes ten instructions: add, sub, and, or, slt, addi, lw, sw, beq and bne. The core holds the program counter, a 32-entry by 32-bit register file, the next-address logic, sign extension, the operand selection, an ALU with a zero flag and the write-back selection. Both memories are outside the core. Instruction fetch is combinational: the core drives an address and receives the instruction word in the same cycle. The data-memory port has an address, write data, read data and separate read and write strobes. A load returns its data combinationally, and a store is committed by the memory on the next rising edge.

The core has no stalls. The program counter is loaded on every rising clock edge. It moves to the next sequential word unless a taken branch selects the branch target. A debug port shows the register-file write of the current instruction: enable, register number and data. This lets a testbench follow the architectural state without looking inside the core.

Top module: `mips1c_core`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, the PC is set to 0 and all 32 registers are set to 0. During reset, `imem_addr` reads 0.
- R2: The PC changes only on a rising edge. For every instruction that is not a taken branch, the next PC is PC+4. `imem_addr` is always word aligned.
- R3: beq (opcode 0x04) is taken when reg[rs]==reg[rt]. bne (opcode 0x05) is taken when they differ. The comparison subtracts the two register values in the ALU and tests the zero flag. A taken branch loads PC+4+(sign-extended imm16 << 2). Branches write no register and access no memory.
- R4: For opcode 0x00 the function field [5:0] selects the operation: 0x20 add, 0x22 sub, 0x24 and, 0x25 or. The result is written to rd (bits [15:11]). The operands are reg[rs] (bits [25:21]) and reg[rt] (bits [20:16]).
- R5: slt (opcode 0x00, function 0x2a) writes 1 to rd when reg[rs] < reg[rt] as signed 32-bit values, and writes 0 otherwise.
- R6: addi (opcode 0x08) writes reg[rs] + sign-extended imm16 (bits [15:0]) to rt. The sum wraps modulo 2^32.
- R7: lw (opcode 0x23) drives `dmem_addr` = reg[rs] + sign-extended imm16 and `dmem_rd`=1, and writes `dmem_rdata` to rt.
- R8: sw (opcode 0x2b) drives `dmem_addr` = reg[rs] + sign-extended imm16, `dmem_wdata` = reg[rt] and `dmem_wr`=1. It writes no register.
- R9: `dmem_rd` and `dmem_wr` are never both 1. Both are 0 for every instruction other than lw and sw.
- R10: Register 0 always reads as 0. A write aimed at register 0 is dropped, and `dbg_we` stays 0 for it.
- R11: An instruction with any other opcode, or opcode 0x00 with any other function code, changes nothing except PC+4.
- R12: In the cycle an instruction is presented, `dbg_we`, `dbg_waddr` and `dbg_wdata` show the register write that will be committed at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (current PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data-memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| dmem_rd | output | 1 | Load strobe |
| dmem_wr | output | 1 | Store strobe, committed at the next rising edge |
| dbg_we | output | 1 | Register-file write enable of the current instruction |
| dbg_waddr | output | 5 | Register number being written |
| dbg_wdata | output | 32 | Value being written |

## Verification
A corrupted register value does not stay hidden. It shows on the debug write port or on the data-memory port at the first later instruction that reads that register, and it shows on `imem_addr` one cycle after a branch compares it. A wrong PC shows directly on `imem_addr` in the cycle after the faulty update. The bench therefore compares the fetch address, both memory strobes, the memory address and data, and the debug write port against an instruction-level model in every cycle. A fault is caught within one instruction of becoming visible. Register 0 gets its own checks: directed code writes it and then reads it back.

// File: rtl/mips1c_core.sv
module mips1c_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata,
  output logic        dmem_rd,
  output logic        dmem_wr,
  output logic        dbg_we,
  output logic [4:0]  dbg_waddr,
  output logic [31:0] dbg_wdata
);
  localparam logic [5:0] OP_RTYPE = 6'h00, OP_BEQ = 6'h04, OP_BNE = 6'h05,
                         OP_ADDI  = 6'h08, OP_LW  = 6'h23, OP_SW  = 6'h2b;
  localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24,
                         FN_OR  = 6'h25, FN_SLT = 6'h2a;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

  logic [31:0] pc, pc_next, pc_seq, br_target;
  logic [31:0] regs [32];

  wire [5:0]  opc  = imem_data[31:26];
  wire [4:0]  rs   = imem_data[25:21];
  wire [4:0]  rt   = imem_data[20:16];
  wire [4:0]  rd   = imem_data[15:11];
  wire [5:0]  fn   = imem_data[5:0];
  wire [31:0] simm = {{16{imem_data[15]}}, imem_data[15:0]};

  logic    sel_rd, sel_imm, wr_en, ld, st, is_br, br_ne;
  alu_op_e alu_op;

  always_comb begin
    sel_rd = 1'b0; sel_imm = 1'b0; wr_en = 1'b0;
    ld = 1'b0; st = 1'b0; is_br = 1'b0; br_ne = 1'b0;
    alu_op = ALU_ADD;
    case (opc)
      OP_RTYPE: begin
        sel_rd = 1'b1;
        wr_en  = 1'b1;
        case (fn)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: wr_en = 1'b0;
        endcase
      end
      OP_ADDI: begin sel_imm = 1'b1; wr_en = 1'b1; end
      OP_LW:   begin sel_imm = 1'b1; wr_en = 1'b1; ld = 1'b1; end
      OP_SW:   begin sel_imm = 1'b1; st = 1'b1; end
      OP_BEQ:  begin is_br = 1'b1; alu_op = ALU_SUB; end
      OP_BNE:  begin is_br = 1'b1; br_ne = 1'b1; alu_op = ALU_SUB; end
      default: ;
    endcase
  end

  wire [31:0] rs_val = (rs == 5'd0) ? 32'h0 : regs[rs];
  wire [31:0] rt_val = (rt == 5'd0) ? 32'h0 : regs[rt];
  wire [31:0] opb    = sel_imm ? simm : rt_val;

  logic [31:0] alu_y;
  always_comb begin
    case (alu_op)
      ALU_SUB: alu_y = rs_val - opb;
      ALU_AND: alu_y = rs_val & opb;
      ALU_OR:  alu_y = rs_val | opb;
      ALU_SLT: alu_y = {31'h0, $signed(rs_val) < $signed(opb)};
      default: alu_y = rs_val + opb;
    endcase
  end
  wire alu_zero = (alu_y == 32'h0);

  wire [4:0]  wsel   = sel_rd ? rd : rt;
  wire [31:0] wvalue = ld ? dmem_rdata : alu_y;
  wire        commit = wr_en && (wsel != 5'd0);
  wire        taken  = is_br && (alu_zero ^ br_ne);

  assign pc_seq    = pc + 32'd4;
  assign br_target = pc_seq + {simm[29:0], 2'b00};
  assign pc_next   = taken ? br_target : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
      for (int i = 0; i < 32; i++) regs[i] <= 32'h0;
    end else begin
      pc <= pc_next;
      if (commit) regs[wsel] <= wvalue;
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_rd    = ld;
  assign dmem_wr    = st;
  assign dbg_we     = commit;
  assign dbg_waddr  = wsel;
  assign dbg_wdata  = wvalue;
endmodule

// File: rtl/mips1c_core_chk.sv
module mips1c_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_data,
  input logic        dmem_rd,
  input logic        dmem_wr,
  input logic        dbg_we,
  input logic [4:0]  dbg_waddr
);
  wire [5:0] opc = imem_data[31:26];

  a_r9_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00);

  a_r2_sequential_pc: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'h04 && opc != 6'h05) |=> imem_addr == $past(imem_addr) + 32'd4);

  a_r10_no_zero_write: assert property (@(posedge clk) disable iff (rst)
    dbg_we |-> dbg_waddr != 5'd0);

  a_r8_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |-> !dbg_we);

  a_r3_branch_no_side_effect: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h04 || opc == 6'h05) |-> !dbg_we && !dmem_rd && !dmem_wr);

  a_r9_mem_only_for_ld_st: assert property (@(posedge clk) disable iff (rst)
    (dmem_rd || dmem_wr) |-> (opc == 6'h23 || opc == 6'h2b));
endmodule

bind mips1c_core mips1c_core_chk u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dbg_we(dbg_we), .dbg_waddr(dbg_waddr)
);

// File: tb/tb_mips1c_core.sv
module tb_mips1c_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_rd, dmem_wr, dbg_we;
  logic [4:0]  dbg_waddr;
  logic [31:0] dbg_wdata;

  logic [31:0] imem  [64];
  logic [31:0] dmem  [64];
  logic [31:0] rdmem [64];
  logic [31:0] rregs [32];
  logic [31:0] rpc;
  string       ptag;
  int          vecs = 0, errs = 0, cycles = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mips1c_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dbg_we(dbg_we),
    .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_wr) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] rins(logic [5:0] fn, logic [4:0] s, logic [4:0] t, logic [4:0] d);
    return {6'h00, s, t, d, 5'h00, fn};
  endfunction
  function automatic logic [31:0] iins(logic [5:0] op, logic [4:0] s, logic [4:0] t, logic [15:0] im);
    return {op, s, t, im};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic ref_cycle();
    logic [31:0] ins, a, b, se, res, npc, ma, md, wd;
    logic [5:0]  op, fn;
    logic [4:0]  wa;
    bit          we, mr, mw;
    string       tag;
    ins = imem[rpc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a  = rregs[ins[25:21]]; b = rregs[ins[20:16]];
    se = {{16{ins[15]}}, ins[15:0]};
    we = 0; mr = 0; mw = 0; wa = 0; wd = 0; ma = 0; md = 0;
    npc = rpc + 4; tag = "R11";
    case (op)
      6'h00: begin
        we = 1; wa = ins[15:11]; tag = "R4";
        case (fn)
          6'h20: wd = a + b;
          6'h22: wd = a - b;
          6'h24: wd = a & b;
          6'h25: wd = a | b;
          6'h2a: begin wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R5"; end
          default: begin we = 0; wa = 0; tag = "R11"; end
        endcase
      end
      6'h08: begin we = 1; wa = ins[20:16]; wd = a + se; tag = "R6"; end
      6'h23: begin we = 1; wa = ins[20:16]; mr = 1; ma = a + se; wd = rdmem[ma[7:2]]; tag = "R7"; end
      6'h2b: begin mw = 1; ma = a + se; md = b; tag = "R8"; end
      6'h04: begin tag = "R3"; if (a == b) npc = rpc + 4 + {se[29:0], 2'b00}; end
      6'h05: begin tag = "R3"; if (a != b) npc = rpc + 4 + {se[29:0], 2'b00}; end
      default: ;
    endcase
    if (we && wa == 0) begin we = 0; tag = "R10"; end

    chk(imem_addr == rpc, (ptag == "R3") ? "R3" : "R2", "pc", imem_addr, rpc);
    chk(dmem_rd == mr, "R9", "dmem_rd", {31'h0, dmem_rd}, {31'h0, mr});
    chk(dmem_wr == mw, "R9", "dmem_wr", {31'h0, dmem_wr}, {31'h0, mw});
    if (mr || mw) chk(dmem_addr == ma, tag, "dmem_addr", dmem_addr, ma);
    if (mw) chk(dmem_wdata == md, "R8", "dmem_wdata", dmem_wdata, md);
    chk(dbg_we == we, (tag == "R10") ? "R10" : "R12", "dbg_we", {31'h0, dbg_we}, {31'h0, we});
    if (we) begin
      chk(dbg_waddr == wa, tag, "dbg_waddr", {27'h0, dbg_waddr}, {27'h0, wa});
      chk(dbg_wdata == wd, tag, "dbg_wdata", dbg_wdata, wd);
    end

    if (we) rregs[wa] = wd;
    if (mw) rdmem[ma[7:2]] = md;
    rpc = npc;
    ptag = tag;
  endtask

  task automatic run(input int ncyc);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      dmem[i] = $urandom;
      rdmem[i] = dmem[i];
    end
    for (int i = 0; i < 32; i++) rregs[i] = 32'h0;
    rpc = 32'h0; ptag = "R1";
    @(negedge clk);
    @(negedge clk);
    chk(imem_addr == 32'h0, "R1", "pc in reset", imem_addr, 32'h0);
    rst = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      ref_cycle();
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] rand_ins();
    logic [4:0] s, t, d;
    logic [5:0] fns [5];
    int k;
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2a;
    s = 5'($urandom % 8); t = 5'($urandom % 8); d = 5'($urandom % 8);
    k = $urandom % 13;
    case (k)
      0, 1, 2, 3, 4: return rins(fns[k], s, t, d);
      5, 6:  return iins(6'h08, s, t, 16'($urandom));
      7:     return iins(6'h23, s, t, 16'($urandom));
      8:     return iins(6'h2b, s, t, 16'($urandom));
      9:     return iins(6'h04, s, t, 16'(int'($urandom % 9) - 4));
      10:    return iins(6'h05, s, t, 16'(int'($urandom % 9) - 4));
      11:    return {6'h3f, 26'($urandom)};
      default: return rins(6'h01, s, t, d);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    imem[0]  = iins(6'h08, 0, 1, 16'd5);        // R6 r1=5
    imem[1]  = iins(6'h08, 0, 2, 16'hfffd);     // R6 r2=-3
    imem[2]  = rins(6'h20, 1, 2, 3);            // R4 add
    imem[3]  = rins(6'h22, 2, 1, 4);            // R4 sub
    imem[4]  = rins(6'h24, 1, 2, 5);            // R4 and
    imem[5]  = rins(6'h25, 1, 2, 6);            // R4 or
    imem[6]  = rins(6'h2a, 2, 1, 7);            // R5 -3<5
    imem[7]  = rins(6'h2a, 1, 2, 8);            // R5 5<-3
    imem[8]  = iins(6'h2b, 0, 1, 16'd8);        // R8 store
    imem[9]  = iins(6'h23, 0, 9, 16'd8);        // R7 load back
    imem[10] = iins(6'h08, 0, 0, 16'd7);        // R10 write to r0
    imem[11] = rins(6'h20, 0, 0, 10);           // R10 r0 reads 0
    imem[12] = iins(6'h04, 1, 1, 16'd1);        // R3 beq taken
    imem[13] = iins(6'h08, 0, 11, 16'd99);      // skipped
    imem[14] = iins(6'h05, 1, 1, 16'd1);        // R3 bne not taken
    imem[15] = iins(6'h05, 1, 2, 16'd1);        // R3 bne taken
    imem[16] = iins(6'h08, 0, 12, 16'd77);      // skipped
    imem[17] = {6'h3f, 26'h3ffffff};            // R11 bad opcode
    imem[18] = rins(6'h01, 1, 2, 13);           // R11 bad funct
    imem[19] = iins(6'h23, 2, 14, 16'h0007);    // R7 negative base
    imem[20] = iins(6'h04, 0, 0, 16'hffeb);     // R3 backward branch to 0
    run(60);
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < 64; i++) imem[i] = rand_ins();
      run(300);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errs++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
      end
    end
  end
endmodule